// File: doc/BRIEF.md
# Single-Slot FIFO with Selectable Enqueue/Dequeue Ordering

This block is a one-entry queue whose behaviour for an enqueue and a dequeue in the same clock cycle is fixed at elaboration by a parameter. The ordering is one of three kinds. In the plain ordering, the two sides never fire together. In the drain-first ordering, a full slot can be refilled in the same cycle that it is emptied. In the fill-first ordering, an empty slot can hand data straight through to the consumer in the cycle it arrives. A producer offers a word with `push_valid`/`push_data` and may push only while `can_push` is high. A consumer takes a word with `pop_ready` while `can_pop` is high and reads `pop_data`.

The storage is a two-state machine, EMPTY and FULL, plus a data register. The transitions are:
- FILL (EMPTY→FULL): a push without a pop.
- DRAIN (FULL→EMPTY): a pop without a push.
- PASS (EMPTY→EMPTY): a push and a pop together, fill-first ordering only.
- SWAP (FULL→FULL): a push and a pop together, drain-first ordering only.
- IDLE: no accepted traffic, so the state holds.

The drain-first ordering makes `can_push` depend combinationally on `pop_ready`. The fill-first ordering makes `can_pop` and `pop_data` depend combinationally on the push inputs. The surrounding logic must therefore not close a loop through those paths.

Top module: `ordered_slot_fifo`

## Requirements
- R1: After reset the slot is EMPTY: with idle inputs `can_pop` is 0 and `can_push` is 1, in every ordering.
- R2: An accepted push without a pop takes EMPTY to FULL (FILL). From the next cycle `pop_data` shows the pushed word.
- R3: An accepted pop without a push takes FULL to EMPTY (DRAIN).
- R4: In the plain ordering (`ORDER` = `ORD_PLAIN`), `can_push` is 1 exactly when EMPTY and `can_pop` is 1 exactly when FULL, whatever the inputs.
- R5: In the plain ordering, a push into a FULL slot is ignored even if a pop is accepted that cycle. A pop from an EMPTY slot is ignored even if a push is accepted. An accepted push and an accepted pop never occur together.
- R6: In the drain-first ordering (`ORD_DRAIN_FIRST`), a FULL slot shows `can_push` = 1 while `pop_ready` is 1. A push and a pop together on a FULL slot leave it FULL holding the new word (SWAP).
- R7: In the drain-first ordering, `can_pop` does not depend on the push inputs. A pop from an EMPTY slot is ignored, and a push alone into a FULL slot is ignored.
- R8: In the fill-first ordering (`ORD_FILL_FIRST`), an EMPTY slot shows `can_pop` = 1 while `push_valid` is 1, with `pop_data` equal to `push_data` in that same cycle.
- R9: In the fill-first ordering, a push and a pop together on an EMPTY slot leave it EMPTY (PASS).
- R10: In the fill-first ordering, `can_push` is 0 whenever the slot is FULL, so a push into a FULL slot is ignored even when a pop is accepted.
- R11: While FULL with no accepted push, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer offers a word |
| push_data | input | DATA_W | Word offered by the producer |
| can_push | output | 1 | A push is accepted this cycle if offered |
| pop_ready | input | 1 | Consumer takes a word |
| pop_data | output | DATA_W | Word presented to the consumer |
| can_pop | output | 1 | A word is available to pop this cycle |

## Verification
The assertions assume nothing about the inputs: requests made while the matching flag is low are legal and are simply dropped. The properties therefore relate accepted transfers to the state and the stored word. Each ordering is instantiated side by side. Every pairing of start state (EMPTY, FULL) with input pattern (none, push, pop, both) is driven, with a reset before every case. Inputs change only on falling edges, so the combinational flags settle before they are sampled.

// File: rtl/slot_fifo_pkg.sv
package slot_fifo_pkg;
    typedef enum logic [1:0] {
        ORD_PLAIN       = 2'd0,
        ORD_DRAIN_FIRST = 2'd1,
        ORD_FILL_FIRST  = 2'd2
    } order_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/slot_flags.sv
module slot_flags
    import slot_fifo_pkg::*;
#(
    parameter order_e ORDER = ORD_PLAIN
) (
    input  logic        clk,
    input  logic        rst_n,
    input  slot_state_e state,
    input  logic        push_valid,
    input  logic        pop_ready,
    output logic        can_push,
    output logic        can_pop,
    output logic        push_fire,
    output logic        pop_fire,
    output logic        pass_through
);
    logic holding;
    assign holding = (state == SLOT_FULL);

    generate
        if (ORDER == ORD_DRAIN_FIRST) begin : g_drain_first
            always_comb begin
                can_pop      = holding;
                can_push     = !holding || pop_ready;
                pass_through = 1'b0;
            end
        end else if (ORDER == ORD_FILL_FIRST) begin : g_fill_first
            always_comb begin
                can_push     = !holding;
                can_pop      = holding || push_valid;
                pass_through = !holding;
            end
            // R10: a full slot never takes a push in fill-first ordering
            a_r10_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
                holding |-> !push_fire);
        end else begin : g_plain
            always_comb begin
                can_push     = !holding;
                can_pop      = holding;
                pass_through = 1'b0;
            end
            // R5: the plain ordering never moves both sides together
            a_r5_plain_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                !(push_fire && pop_fire));
        end
    endgenerate

    assign push_fire = push_valid && can_push;
    assign pop_fire  = pop_ready && can_pop;
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
    import slot_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_fire,
    input  logic        pop_fire,
    output slot_state_e state
);
    slot_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_EMPTY: begin
                if (push_fire && !pop_fire) state_nx = SLOT_FULL;   // FILL
                else                        state_nx = SLOT_EMPTY;  // PASS / IDLE
            end
            SLOT_FULL: begin
                if (pop_fire && !push_fire) state_nx = SLOT_EMPTY;  // DRAIN
                else                        state_nx = SLOT_FULL;   // SWAP / IDLE
            end
            default: state_nx = SLOT_EMPTY;
        endcase
    end

    a_r3_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_FULL && pop_fire && !push_fire) |=> state == SLOT_EMPTY);
    a_r2_fill_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_EMPTY && push_fire && !pop_fire) |=> state == SLOT_FULL);
    a_r6_swap_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_FULL && push_fire && pop_fire) |=> state == SLOT_FULL);
    a_r9_pass_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_EMPTY && push_fire && pop_fire) |=> state == SLOT_EMPTY);
endmodule

// File: rtl/slot_store.sv
module slot_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_fire,
    input  logic              pass_through,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data
);
    logic [DATA_W-1:0] stored;

    always_ff @(posedge clk) begin
        if (push_fire) stored <= push_data;
    end

    assign pop_data = pass_through ? push_data : stored;

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        push_fire |=> stored == $past(push_data));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push_fire |=> $stable(stored));
endmodule

// File: rtl/ordered_slot_fifo.sv
module ordered_slot_fifo
    import slot_fifo_pkg::*;
#(
    parameter int     DATA_W = 8,
    parameter order_e ORDER  = ORD_PLAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              can_push,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data,
    output logic              can_pop
);
    slot_state_e state;
    logic        push_fire;
    logic        pop_fire;
    logic        pass_through;

    slot_flags #(.ORDER(ORDER)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .push_valid   (push_valid),
        .pop_ready    (pop_ready),
        .can_push     (can_push),
        .can_pop      (can_pop),
        .push_fire    (push_fire),
        .pop_fire     (pop_fire),
        .pass_through (pass_through)
    );

    slot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_fire (push_fire),
        .pop_fire  (pop_fire),
        .state     (state)
    );

    slot_store #(.DATA_W(DATA_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_fire    (push_fire),
        .pass_through (pass_through),
        .push_data    (push_data),
        .pop_data     (pop_data)
    );

    // R8: in fill-first ordering an empty slot forwards the offered word
    a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (ORDER == ORD_FILL_FIRST && state == SLOT_EMPTY && push_valid)
            |-> (can_pop && pop_data == push_data));
endmodule

// File: tb/tb_ordered_slot_fifo.sv
module tb_ordered_slot_fifo;
    import slot_fifo_pkg::*;

    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          pv [3];
    logic [DW-1:0] pd [3];
    logic          pr [3];
    logic          cpu [3];
    logic          cpo [3];
    logic [DW-1:0] pod [3];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    for (genvar m = 0; m < 3; m++) begin : g_mode
        ordered_slot_fifo #(.DATA_W(DW), .ORDER(order_e'(m))) dut (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (pv[m]),
            .push_data  (pd[m]),
            .can_push   (cpu[m]),
            .pop_ready  (pr[m]),
            .pop_data   (pod[m]),
            .can_pop    (cpo[m])
        );
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string flag_tag(int m, bit is_push);
        if (m == 0) return "R4";
        if (m == 1) return is_push ? "R6" : "R7";
        return is_push ? "R10" : "R8";
    endfunction

    function automatic string next_tag(int m, bit ef, bit df, bit en, bit dq);
        if (ef && df) return (m == 1) ? "R6" : "R9";
        if (ef) return "R2";
        if (df) return "R3";
        if (en || dq) return (m == 0) ? "R5" : (m == 1) ? "R7" : "R10";
        return "R11";
    endfunction

    task automatic idle_all();
        for (int k = 0; k < 3; k++) begin
            pv[k] = 1'b0; pr[k] = 1'b0; pd[k] = '0;
        end
    endtask

    task automatic run_case(int m, bit full, int op);
        bit en, dq, nf, ne, ef, df, nxt;
        logic [DW-1:0] a, b, exp_d;
        en = op[0];
        dq = op[1];
        a = DW'(8'h51 + 16 * m + 4 * op + full);
        b = ~a;
        @(negedge clk); rst_n = 1'b0; idle_all();
        @(negedge clk); rst_n = 1'b1;
        if (full) begin
            pv[m] = 1'b1; pd[m] = a;
            @(negedge clk); idle_all();
        end
        nf = !full || (m == 1 && dq);
        ne = full || (m == 2 && en);
        ef = en && nf;
        df = dq && ne;
        nxt = full ? (!df || ef) : (ef && !df);
        pv[m] = en; pr[m] = dq; pd[m] = b;
        #1;
        chk({flag_tag(m, 1'b1), " can_push"}, int'(cpu[m]), int'(nf));
        chk({flag_tag(m, 1'b0), " can_pop"}, int'(cpo[m]), int'(ne));
        if (ne) begin
            exp_d = full ? a : b;
            chk({flag_tag(m, 1'b0), " pop_data"}, int'(pod[m]), int'(exp_d));
        end
        @(negedge clk); idle_all();
        #1;
        chk({next_tag(m, ef, df, en, dq), " next can_pop"}, int'(cpo[m]), int'(nxt));
        chk({next_tag(m, ef, df, en, dq), " next can_push"}, int'(cpu[m]), int'(!nxt));
        if (nxt) begin
            exp_d = ef ? b : a;
            chk({next_tag(m, ef, df, en, dq), " next pop_data"}, int'(pod[m]), int'(exp_d));
            @(negedge clk); #1;
            chk("R11 held word", int'(pod[m]), int'(exp_d));
        end
    endtask

    initial begin
        idle_all();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int m = 0; m < 3; m++) begin
            chk("R1 reset can_pop", int'(cpo[m]), 0);
            chk("R1 reset can_push", int'(cpu[m]), 1);
        end
        for (int m = 0; m < 3; m++)
            for (int s = 0; s < 2; s++)
                for (int op = 0; op < 4; op++)
                    run_case(m, s[0], op);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule